// File: doc/BRIEF.md
# Offset-Binary Partial Product Selector

This block turns one bit-slice of four filter coefficients into the matching partial product for a fourth-order distributed-arithmetic filter that uses offset-binary coding. No lookup memory is kept. Each slice bit is read as a digit of +1 (bit 1) or −1 (bit 0). The block forms the half-scaled weighted sum of the four newest samples on the fly, using a small tree of conditional adders.

Each sample is halved by dropping its least significant bit. The tree first combines sample pairs (x0,x1) and (x2,x3), each by add or subtract. It then adds or subtracts the two pair results and finally applies the overall sign taken from the reference bit w[0]. All add/subtract choices come straight from XORs of coefficient bits. The result is registered, and a strobe marks it for a downstream shift-accumulator that consumes one partial product per slice.

Top module: `obc_pp_sel`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears pp to 0 and pp_valid to 0, and takes priority over a simultaneous in_valid.
- R2: One clock after an edge where in_valid is high, pp equals the sum over i=0..3 of d_i·(x_i >>> 1), where d_i is +1 when w[i] is 1 and −1 when w[i] is 0, and >>> is an arithmetic shift of the signed SAMPLE_W-bit sample.
- R3: Bit 0 of every sample has no effect on pp.
- R4: pp_valid is high for exactly the cycle after each edge with in_valid high and rst low, and is low otherwise.
- R5: While in_valid is low, pp holds its last value.
- R6: Inverting all four bits of w yields the exact two's-complement negation of pp for the same samples.
- R7: pp is SAMPLE_W+2 bits, signed. It holds the full range −2^SAMPLE_W to +2^SAMPLE_W without wrap, including all samples at the most negative value with w = 4'b0000.
- R8: Bit w[i] weights sample x_i (w[0] with x0 through w[3] with x3), and w[0] is the reference bit that sets the final sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a new bit-slice on w and the samples |
| x0 | input | SAMPLE_W | Newest sample, signed |
| x1 | input | SAMPLE_W | Sample one step older, signed |
| x2 | input | SAMPLE_W | Sample two steps older, signed |
| x3 | input | SAMPLE_W | Sample three steps older, signed |
| w | input | 4 | Current coefficient bit-slice, bit i for sample x_i |
| pp | output | SAMPLE_W+2 | Registered partial product, signed |
| pp_valid | output | 1 | High in the cycle pp holds a fresh result |

## Verification
A reset and a valid strobe can arrive in the same cycle, and the block must discard the slice rather than register it. The bench raises rst and in_valid together with non-zero samples. It then checks that pp is zero and pp_valid is low after that edge. It also checks that a slice applied right after reset releases comes out normally. The arithmetic is judged against an integer model of the signed digit sum, over mixed, extreme and single-sample patterns.

// File: rtl/obc_pp_sel.sv
module obc_pp_sel #(
  parameter int SAMPLE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [SAMPLE_W-1:0]   x0,
  input  logic [SAMPLE_W-1:0]   x1,
  input  logic [SAMPLE_W-1:0]   x2,
  input  logic [SAMPLE_W-1:0]   x3,
  input  logic [3:0]            w,
  output logic [SAMPLE_W+1:0]   pp,
  output logic                  pp_valid
);
  localparam int OUT_W  = SAMPLE_W + 2;
  localparam int HALF_W = SAMPLE_W - 1;

  logic signed [OUT_W-1:0] h0, h1, h2, h3;
  logic signed [OUT_W-1:0] pair_a, pair_b, tree, signed_pp;
  logic sub_a, sub_b, sub_o, negate;

  // halving: drop the LSB, sign-extend to the output width
  assign h0 = OUT_W'($signed(x0[SAMPLE_W-1:1]));
  assign h1 = OUT_W'($signed(x1[SAMPLE_W-1:1]));
  assign h2 = OUT_W'($signed(x2[SAMPLE_W-1:1]));
  assign h3 = OUT_W'($signed(x3[SAMPLE_W-1:1]));

  assign sub_a  = w[1] ^ w[0];
  assign sub_b  = w[3] ^ w[2];
  assign sub_o  = w[2] ^ w[0];
  assign negate = ~w[0];

  assign pair_a    = h0 + (h1 ^ {OUT_W{sub_a}}) + OUT_W'(sub_a);
  assign pair_b    = h2 + (h3 ^ {OUT_W{sub_b}}) + OUT_W'(sub_b);
  assign tree      = pair_a + (pair_b ^ {OUT_W{sub_o}}) + OUT_W'(sub_o);
  assign signed_pp = (tree ^ {OUT_W{negate}}) + OUT_W'(negate);

  always_ff @(posedge clk) begin
    if (rst) begin
      pp       <= '0;
      pp_valid <= 1'b0;
    end else begin
      pp_valid <= in_valid;
      if (in_valid) pp <= signed_pp;
    end
  end

  // independent digit-sum model for checking
  logic signed [OUT_W-1:0] model_sum;
  always_comb begin
    model_sum = (w[0] ? h0 : -h0) + (w[1] ? h1 : -h1)
              + (w[2] ? h2 : -h2) + (w[3] ? h3 : -h3);
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (pp == '0 && !pp_valid));

  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> pp_valid);

  a_r4_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !pp_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(pp));

  a_r2_value: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ($signed(pp) == $past(model_sum)));

  a_r7_range: assert property (@(posedge clk) disable iff (rst)
    pp_valid |-> ($signed(pp) <= $signed(OUT_W'(1) << HALF_W + 1) &&
                  $signed(pp) >= -$signed(OUT_W'(1) << HALF_W + 1)));
endmodule

// File: tb/obc_pp_sel_tb_top.sv
module obc_pp_sel_tb_top;
  localparam int SW = 8;

  logic clk = 1'b0;
  logic rst, in_valid;
  logic [SW-1:0] x0, x1, x2, x3;
  logic [3:0] w;
  logic [SW+1:0] pp;
  logic pp_valid;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  obc_pp_sel #(.SAMPLE_W(SW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .x0(x0), .x1(x1), .x2(x2), .x3(x3), .w(w),
    .pp(pp), .pp_valid(pp_valid)
  );

  function automatic int half(input int v);
    logic signed [SW-1:0] s;
    s = SW'(v);
    return int'(s) >>> 1;
  endfunction

  function automatic int model(input int a, b, c, d, input logic [3:0] ww);
    int r;
    r  = ww[0] ? half(a) : -half(a);
    r += ww[1] ? half(b) : -half(b);
    r += ww[2] ? half(c) : -half(c);
    r += ww[3] ? half(d) : -half(d);
    return r;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic apply(input int a, b, c, d, input logic [3:0] ww);
    @(negedge clk);
    x0 = SW'(a); x1 = SW'(b); x2 = SW'(c); x3 = SW'(d); w = ww;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int ppv();
    return int'($signed(pp));
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    x0 = 8'd100; x1 = 8'd50; x2 = 8'd20; x3 = 8'd7; w = 4'b1111;
    @(negedge clk);
    check("R1 pp", ppv(), 0);
    check("R1 pp_valid", int'(pp_valid), 0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    check("R1 after release", int'(pp_valid), 0);
  endtask

  task automatic t_value();
    int pats[6][4] = '{'{10, 20, 30, 40}, '{-17, 33, -65, 90},
                       '{127, -128, 5, -6}, '{1, 1, 1, 1},
                       '{-2, 64, -100, 3}, '{55, -55, 77, -77}};
    for (int p = 0; p < 6; p++) begin
      for (int k = 0; k < 16; k += 5) begin
        apply(pats[p][0], pats[p][1], pats[p][2], pats[p][3], 4'(k));
        check("R2 value", ppv(),
              model(pats[p][0], pats[p][1], pats[p][2], pats[p][3], 4'(k)));
        check("R4 strobe", int'(pp_valid), 1);
      end
    end
  endtask

  task automatic t_lsb();
    int ref_v;
    apply(40, -30, 22, 14, 4'b1010);
    ref_v = ppv();
    apply(41, -29, 23, 15, 4'b1010);
    check("R3 lsb ignored", ppv(), ref_v);
  endtask

  task automatic t_valid_hold();
    int held;
    apply(60, 12, -8, 4, 4'b0110);
    held = ppv();
    @(negedge clk);
    x0 = 8'd99; x1 = 8'd1; w = 4'b1111;
    @(negedge clk);
    check("R4 strobe low", int'(pp_valid), 0);
    check("R5 hold", ppv(), held);
  endtask

  task automatic t_symmetry();
    for (int k = 0; k < 16; k++) begin
      int pos;
      apply(70, -45, 12, -99, 4'(k));
      pos = ppv();
      apply(70, -45, 12, -99, ~4'(k));
      check("R6 negation", ppv(), -pos);
    end
  endtask

  task automatic t_extreme();
    apply(-128, -128, -128, -128, 4'b0000);
    check("R7 max positive", ppv(), 256);
    apply(-128, -128, -128, -128, 4'b1111);
    check("R7 max negative", ppv(), -256);
    apply(127, 127, 127, 127, 4'b1111);
    check("R7 all high", ppv(), 252);
  endtask

  task automatic t_order();
    for (int i = 0; i < 4; i++) begin
      int v[4] = '{0, 0, 0, 0};
      v[i] = 64;
      apply(v[0], v[1], v[2], v[3], 4'(1 << i));
      check("R8 bit pairing", ppv(), 32);
      apply(v[0], v[1], v[2], v[3], ~4'(1 << i));
      check("R8 bit pairing neg", ppv(), -32);
    end
  endtask

  initial begin
    fork
      begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none
    rst = 1'b1; in_valid = 1'b0;
    x0 = '0; x1 = '0; x2 = '0; x3 = '0; w = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", ppv(), 0);
    t_reset();
    t_value();
    t_lsb();
    t_valid_hold();
    t_symmetry();
    t_extreme();
    t_order();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule